// File: doc/BRIEF.md
# MII Duplex and Loopback Control

This block sits between the nibble-wide MII port of a MAC and a simplified media-side port of an Ethernet PHY. It produces carrier sense (CRS) and collision (COL) for the MAC from transmit and receive activity, and the selected duplex mode decides how. In half duplex, carrier follows both directions and overlapping traffic is flagged as a collision. In full duplex, carrier follows received traffic only and collision reporting is switched off.

The block also provides an internal loopback for diagnostics. Software sets a loopback enable bit in a control word. From the next nibble strobe onward, the MAC's transmit nibbles come back on its receive outputs, and the media transmit side stays idle. A status word reports whether loopback is in force. The nibble strobe marks each nibble boundary at either line rate, so 10 Mb/s and 100 Mb/s traffic go through the same logic.

Top module: `mii_duplex_loop`

## Requirements
- R1: In half duplex (`full_duplex`=0) and with no loopback, the `mac_crs` value captured at a nibble strobe is the OR of `mac_tx_en` and `media_rx_dv`.
- R2: In full duplex (`full_duplex`=1) and with no loopback, `mac_crs` follows `media_rx_dv` only, whatever `mac_tx_en` is.
- R3: `mac_col` is captured as 1 only when the block is in half duplex, not in loopback, and both `mac_tx_en` and `media_rx_dv` are 1. In full duplex it is always 0.
- R4: With no loopback, the receive lane (`media_rx_dv`, `media_rx_er`, `media_rxd`) reaches the MAC unchanged and the transmit lane (`mac_tx_en`, `mac_tx_er`, `mac_txd`) reaches the media unchanged, identically in both duplex modes.
- R5: A control write with bit 14 of `ctrl_wdata` set to 1 enables loopback. While loopback is on, `mac_rx_dv` equals the captured `mac_tx_en`, `mac_rxd` equals the captured `mac_txd`, and `mac_crs` equals `mac_tx_en`.
- R6: While loopback is on, `media_tx_en`, `media_tx_er` and `media_txd` are all 0.
- R7: While loopback is on, the media receive inputs are ignored and `mac_rx_er` is 0.
- R8: Bit 3 of `status_word` is 1 exactly while loopback is in force. All other status bits read 0.
- R9: A control write changes the loopback state only at the first nibble strobe after the write cycle. Writing bit 14 as 0 disables loopback. The other control bits have no effect.
- R10: All outputs change only on clock edges where `nib_en` is 1. After reset, all outputs and the status word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_en | input | 1 | Nibble-boundary strobe; all lanes advance on it |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word; bit 14 = loopback enable |
| status_word | output | 16 | Status; bit 3 = loopback active |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_er | input | 1 | MAC transmit error |
| mac_txd | input | 4 | MAC transmit nibble |
| mac_rx_dv | output | 1 | Receive data valid to MAC |
| mac_rx_er | output | 1 | Receive error to MAC |
| mac_rxd | output | 4 | Receive nibble to MAC |
| mac_crs | output | 1 | Carrier sense to MAC |
| mac_col | output | 1 | Collision to MAC |
| media_tx_en | output | 1 | Transmit enable toward media |
| media_tx_er | output | 1 | Transmit error toward media |
| media_txd | output | 4 | Transmit nibble toward media |
| media_rx_dv | input | 1 | Receive data valid from media |
| media_rx_er | input | 1 | Receive error from media |
| media_rxd | input | 4 | Receive nibble from media |

## Verification
The hardest situation to reach is the gap between a control write and the strobe that applies it. During that gap the requested and the active loopback states differ, and outputs must not move. The bench writes the control word and then, before any strobe, changes the lane inputs and reads the status. It then strobes once and checks that the new mode and the new data appear together. The main sweep covers every combination of duplex, loopback, the four lane flags and both nibbles. After each captured nibble, it inverts all inputs without a strobe to confirm that the outputs hold.

// File: rtl/mii_dlb_pkg.sv
package mii_dlb_pkg;

    localparam int NIB_W = 4;

    typedef enum logic {
        DPX_HALF = 1'b0,
        DPX_FULL = 1'b1
    } duplex_e;

    typedef struct packed {
        logic             act;
        logic             err;
        logic [NIB_W-1:0] dat;
    } nib_lane_t;

    localparam nib_lane_t LANE_IDLE = '{act: 1'b0, err: 1'b0, dat: '0};

    function automatic logic carrier_of(duplex_e dpx, logic tx_act, logic rx_act);
        if (dpx == DPX_FULL) begin
            return rx_act;
        end
        return tx_act | rx_act;
    endfunction

    function automatic logic collision_of(duplex_e dpx, logic looped,
                                          logic tx_act, logic rx_act);
        if (dpx == DPX_FULL || looped) begin
            return 1'b0;
        end
        return tx_act & rx_act;
    endfunction

endpackage

// File: rtl/dlb_ctrl.sv
module dlb_ctrl
    import mii_dlb_pkg::*;
#(
    parameter int CTRL_W      = 16,
    parameter int LB_CTRL_BIT = 14,
    parameter int LB_STS_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nib_en,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              lb_req,
    output logic              lb_act,
    output logic [CTRL_W-1:0] status_word
);

    logic req_q;
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else if (ctrl_we) begin
            req_q <= ctrl_wdata[LB_CTRL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
        end else if (nib_en) begin
            act_q <= req_q;
        end
    end

    for (genvar b = 0; b < CTRL_W; b++) begin : g_sts
        if (b == LB_STS_BIT) begin : g_lb
            assign status_word[b] = act_q;
        end else begin : g_zero
            assign status_word[b] = 1'b0;
        end
    end

    assign lb_req = req_q;
    assign lb_act = act_q;

endmodule

// File: rtl/dlb_path_mux.sv
module dlb_path_mux
    import mii_dlb_pkg::*;
(
    input  logic      looped,
    input  nib_lane_t from_mac,
    input  nib_lane_t from_media,
    output nib_lane_t to_media,
    output nib_lane_t to_mac
);

    always_comb begin
        if (looped) begin
            to_media   = LANE_IDLE;
            to_mac.act = from_mac.act;
            to_mac.err = 1'b0;
            to_mac.dat = from_mac.dat;
        end else begin
            to_media = from_mac;
            to_mac   = from_media;
        end
    end

endmodule

// File: rtl/dlb_sense.sv
module dlb_sense
    import mii_dlb_pkg::*;
(
    input  duplex_e dpx,
    input  logic    looped,
    input  logic    tx_act,
    input  logic    rx_act,
    output logic    crs,
    output logic    col
);

    always_comb begin
        crs = carrier_of(dpx, tx_act, rx_act);
        col = collision_of(dpx, looped, tx_act, rx_act);
    end

endmodule

// File: rtl/mii_duplex_loop.sv
module mii_duplex_loop
    import mii_dlb_pkg::*;
#(
    parameter int CTRL_W      = 16,
    parameter int LB_CTRL_BIT = 14,
    parameter int LB_STS_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nib_en,
    input  logic              full_duplex,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] status_word,
    input  logic              mac_tx_en,
    input  logic              mac_tx_er,
    input  logic [NIB_W-1:0]  mac_txd,
    output logic              mac_rx_dv,
    output logic              mac_rx_er,
    output logic [NIB_W-1:0]  mac_rxd,
    output logic              mac_crs,
    output logic              mac_col,
    output logic              media_tx_en,
    output logic              media_tx_er,
    output logic [NIB_W-1:0]  media_txd,
    input  logic              media_rx_dv,
    input  logic              media_rx_er,
    input  logic [NIB_W-1:0]  media_rxd
);

    logic      lb_req;
    logic      lb_act;
    duplex_e   dpx;
    nib_lane_t tx_in;
    nib_lane_t rx_in;
    nib_lane_t media_d;
    nib_lane_t mac_d;
    nib_lane_t media_q;
    nib_lane_t mac_q;
    logic      crs_d;
    logic      col_d;
    logic      crs_q;
    logic      col_q;

    assign dpx   = full_duplex ? DPX_FULL : DPX_HALF;
    assign tx_in = '{act: mac_tx_en, err: mac_tx_er, dat: mac_txd};
    assign rx_in = '{act: media_rx_dv, err: media_rx_er, dat: media_rxd};

    dlb_ctrl #(
        .CTRL_W      (CTRL_W),
        .LB_CTRL_BIT (LB_CTRL_BIT),
        .LB_STS_BIT  (LB_STS_BIT)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .nib_en      (nib_en),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .lb_req      (lb_req),
        .lb_act      (lb_act),
        .status_word (status_word)
    );

    dlb_path_mux u_mux (
        .looped     (lb_req),
        .from_mac   (tx_in),
        .from_media (rx_in),
        .to_media   (media_d),
        .to_mac     (mac_d)
    );

    dlb_sense u_sense (
        .dpx    (dpx),
        .looped (lb_req),
        .tx_act (tx_in.act),
        .rx_act (mac_d.act),
        .crs    (crs_d),
        .col    (col_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            media_q <= LANE_IDLE;
            mac_q   <= LANE_IDLE;
            crs_q   <= 1'b0;
            col_q   <= 1'b0;
        end else if (nib_en) begin
            media_q <= media_d;
            mac_q   <= mac_d;
            crs_q   <= crs_d;
            col_q   <= col_d;
        end
    end

    assign media_tx_en = media_q.act;
    assign media_tx_er = media_q.err;
    assign media_txd   = media_q.dat;
    assign mac_rx_dv   = mac_q.act;
    assign mac_rx_er   = mac_q.err;
    assign mac_rxd     = mac_q.dat;
    assign mac_crs     = crs_q;
    assign mac_col     = col_q;

endmodule

// File: rtl/mii_dlb_chk.sv
module mii_dlb_chk (
    input logic        clk,
    input logic        rst,
    input logic        nib_en,
    input logic        full_duplex,
    input logic        mac_tx_en,
    input logic        media_rx_dv,
    input logic        mac_crs,
    input logic        mac_col,
    input logic        mac_rx_dv,
    input logic        mac_rx_er,
    input logic        media_tx_en,
    input logic [15:0] status_word,
    input logic        lb_req,
    input logic        lb_act
);

    p_half_crs_r1: assert property (@(posedge clk) disable iff (rst)
        nib_en && !full_duplex && !lb_req |=> mac_crs == $past(mac_tx_en || media_rx_dv));

    p_full_crs_r2: assert property (@(posedge clk) disable iff (rst)
        nib_en && full_duplex && !lb_req |=> mac_crs == $past(media_rx_dv));

    p_full_nocol_r3: assert property (@(posedge clk) disable iff (rst)
        nib_en && full_duplex |=> !mac_col);

    p_loop_echo_r5: assert property (@(posedge clk) disable iff (rst)
        nib_en && lb_req |=> mac_rx_dv == $past(mac_tx_en));

    p_loop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        lb_act |-> !media_tx_en);

    p_loop_rxer_r7: assert property (@(posedge clk) disable iff (rst)
        lb_act |-> !mac_rx_er);

    p_sts_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !nib_en |=> $stable(status_word));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !nib_en |=> $stable(mac_crs) && $stable(mac_col) && $stable(mac_rx_dv)
                    && $stable(media_tx_en));

endmodule

bind mii_duplex_loop mii_dlb_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .nib_en      (nib_en),
    .full_duplex (full_duplex),
    .mac_tx_en   (mac_tx_en),
    .media_rx_dv (media_rx_dv),
    .mac_crs     (mac_crs),
    .mac_col     (mac_col),
    .mac_rx_dv   (mac_rx_dv),
    .mac_rx_er   (mac_rx_er),
    .media_tx_en (media_tx_en),
    .status_word (status_word),
    .lb_req      (lb_req),
    .lb_act      (lb_act)
);

// File: tb/mii_duplex_loop_test.sv
module mii_duplex_loop_test;

    logic        clk;
    logic        rst;
    logic        nib_en;
    logic        full_duplex;
    logic        ctrl_we;
    logic [15:0] ctrl_wdata;
    logic [15:0] status_word;
    logic        mac_tx_en;
    logic        mac_tx_er;
    logic [3:0]  mac_txd;
    logic        mac_rx_dv;
    logic        mac_rx_er;
    logic [3:0]  mac_rxd;
    logic        mac_crs;
    logic        mac_col;
    logic        media_tx_en;
    logic        media_tx_er;
    logic [3:0]  media_txd;
    logic        media_rx_dv;
    logic        media_rx_er;
    logic [3:0]  media_rxd;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 0;

    mii_duplex_loop uut (
        .clk         (clk),
        .rst         (rst),
        .nib_en      (nib_en),
        .full_duplex (full_duplex),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .status_word (status_word),
        .mac_tx_en   (mac_tx_en),
        .mac_tx_er   (mac_tx_er),
        .mac_txd     (mac_txd),
        .mac_rx_dv   (mac_rx_dv),
        .mac_rx_er   (mac_rx_er),
        .mac_rxd     (mac_rxd),
        .mac_crs     (mac_crs),
        .mac_col     (mac_col),
        .media_tx_en (media_tx_en),
        .media_tx_er (media_tx_er),
        .media_txd   (media_txd),
        .media_rx_dv (media_rx_dv),
        .media_rx_er (media_rx_er),
        .media_rxd   (media_rxd)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic strobe();
        nib_en = 1'b1;
        @(negedge clk);
        nib_en = 1'b0;
    endtask

    task automatic ctrl_write(input logic [15:0] w);
        ctrl_we    = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we    = 1'b0;
        ctrl_wdata = 16'h0000;
    endtask

    task automatic drive(input logic fd, input logic [3:0] flags,
                         input logic [3:0] txd, input logic [3:0] rxd);
        full_duplex = fd;
        mac_tx_en   = flags[0];
        mac_tx_er   = flags[1];
        media_rx_dv = flags[2];
        media_rx_er = flags[3];
        mac_txd     = txd;
        media_rxd   = rxd;
    endtask

    task automatic expect_all(input logic fd, input logic lb, input logic [3:0] flags,
                              input logic [3:0] txd, input logic [3:0] rxd);
        logic       tx_en;
        logic       tx_er;
        logic       rx_dv;
        logic       rx_er;
        logic [5:0] exp_mac;
        logic [5:0] exp_med;
        logic       exp_crs;
        logic       exp_col;
        tx_en = flags[0];
        tx_er = flags[1];
        rx_dv = flags[2];
        rx_er = flags[3];
        if (lb) begin
            exp_mac = {tx_en, 1'b0, txd};
            exp_med = 6'd0;
            exp_crs = tx_en;
            exp_col = 1'b0;
            check("R5 rx lane echo", {mac_rx_dv, mac_rxd}, {exp_mac[5], exp_mac[3:0]});
            check("R7 rx_er low", mac_rx_er, 1'b0);
            check("R6 media quiet", {media_tx_en, media_tx_er, media_txd}, exp_med);
            check("R5 crs in loop", mac_crs, exp_crs);
            check("R3 col in loop", mac_col, exp_col);
            check("R8 status", status_word, 16'h0008);
        end else begin
            exp_mac = {rx_dv, rx_er, rxd};
            exp_med = {tx_en, tx_er, txd};
            exp_crs = fd ? rx_dv : (tx_en | rx_dv);
            exp_col = !fd & tx_en & rx_dv;
            check("R4 rx lane", {mac_rx_dv, mac_rx_er, mac_rxd}, exp_mac);
            check("R4 tx lane", {media_tx_en, media_tx_er, media_txd}, exp_med);
            check(fd ? "R2 crs" : "R1 crs", mac_crs, exp_crs);
            check("R3 col", mac_col, exp_col);
            check("R8 status", status_word, 16'h0000);
        end
    endtask

    initial begin
        rst = 1'b1;
        nib_en = 1'b0;
        ctrl_we = 1'b0;
        ctrl_wdata = 16'h0000;
        drive(1'b0, 4'h0, 4'h0, 4'h0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check("R10 reset outputs",
              {mac_rx_dv, mac_rx_er, mac_rxd, mac_crs, mac_col,
               media_tx_en, media_tx_er, media_txd}, 0);
        check("R10 reset status", status_word, 16'h0000);

        // R9: write enable, then no strobe yet
        ctrl_write(16'h4000);
        drive(1'b0, 4'h5, 4'hA, 4'h3);
        @(negedge clk);
        check("R9 pending write no effect", status_word, 16'h0000);
        check("R10 hold without strobe", {mac_rx_dv, media_tx_en, mac_crs}, 3'b000);
        drive(1'b0, 4'h1, 4'h5, 4'hC);
        strobe();
        check("R9 applied at strobe", status_word, 16'h0008);
        check("R5 echo after enable", {mac_rx_dv, mac_rxd}, 5'b1_0101);
        check("R6 media blocked", media_tx_en, 1'b0);

        // R9: disable via bit14=0 with other bits set
        ctrl_write(16'hBFFF);
        check("R9 disable pending", status_word, 16'h0008);
        drive(1'b0, 4'h0, 4'h0, 4'h0);
        strobe();
        check("R9 disable applied", status_word, 16'h0000);

        // R9: other bits alone do nothing while off
        ctrl_write(16'hBFFF);
        strobe();
        check("R9 other bits ignored", status_word, 16'h0000);

        // Sweep
        for (int lb = 0; lb < 2; lb++) begin
            ctrl_write(lb[0] ? 16'h4A5A : 16'h0A5A);
            drive(1'b0, 4'h0, 4'h0, 4'h0);
            strobe();
            check("R9 sweep mode", status_word, lb[0] ? 16'h0008 : 16'h0000);
            for (int fd = 0; fd < 2; fd++) begin
                for (int fl = 0; fl < 16; fl++) begin
                    for (int tx = 0; tx < 16; tx++) begin
                        for (int rx = 0; rx < 16; rx++) begin
                            drive(fd[0], fl[3:0], tx[3:0], rx[3:0]);
                            strobe();
                            expect_all(fd[0], lb[0], fl[3:0], tx[3:0], rx[3:0]);
                            drive(~fd[0], ~fl[3:0], ~tx[3:0], ~rx[3:0]);
                            @(negedge clk);
                            // R10: inputs changed without strobe, outputs hold
                            expect_all(fd[0], lb[0], fl[3:0], tx[3:0], rx[3:0]);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule